// File: doc/BRIEF.md
# BCD Year Counter with Leap Flag

This block holds the year of a real-time-clock calendar as two packed BCD digits and steps it forward by one each time the month stage signals the end of a year. A host reads the stored year on a byte port and can load a new year through a write strobe and data byte. A combinational leap flag, derived straight from the BCD digits, goes to the day-of-month limit logic so that February can run to 29 days.

Host loads take effect only while the run control is low, so software must stop the calendar before setting the year. The year carry from the month stage is not gated by the run control, because that stage stops issuing carries once the calendar is halted. When a host load and a carry land in the same cycle, the load wins. Reset does not clear the year. While reset is held low, the stored value is frozen.

Top module: `rtc_year_stage`

## Requirements
- R1: `rd_data` presents the stored year in packed BCD, with the tens digit in bits [7:4] and the units digit in bits [3:0]. It updates on the clock edge that performs a load or a count.
- R2: With `wr_en`=1 and `run_en`=0, the year takes the value of `wr_data` at the next clock edge.
- R3: With `run_en`=1, `wr_en` has no effect on the stored year.
- R4: With `yr_carry`=1 and no accepted host load, the year advances by one in decimal at the next edge, whatever the value of `run_en`.
- R5: Counting carries from units to tens (09 becomes 10), and 99 wraps to 00.
- R6: When a host load is accepted in the same cycle as `yr_carry`=1, the loaded value is stored and the carry is dropped.
- R7: `leap` is 1 exactly when the stored decimal year is a multiple of 4. It follows `rd_data` with no added delay.
- R8: In a cycle with neither an accepted load nor a carry, the year is unchanged.
- R9: While `rst_n` is low, the year is neither cleared nor changed by `yr_carry` or `wr_en`, and the stored value is still there after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Calendar clock |
| rst_n | input | 1 | Active-low reset; freezes updates but does not clear the year |
| run_en | input | 1 | 1 = calendar running (host loads ignored), 0 = halted |
| yr_carry | input | 1 | One-cycle year carry from the month stage |
| wr_en | input | 1 | Host load strobe |
| wr_data | input | 8 | Host load value, packed BCD |
| rd_data | output | 8 | Stored year, packed BCD |
| leap | output | 1 | 1 when the stored year is divisible by 4 |

## Verification
Every load and count becomes visible on `rd_data` one edge after the cycle that requests it. `leap` is decoded from that same register with no extra stage, so it is due in the same cycle as `rd_data`. The bench drives each stimulus on a falling edge and records the expected year and leap value at that moment. The monitor then compares both outputs a short time after the following rising edge, so every comparison lands in the one cycle where the result is due. A sweep of one hundred carries from 00 passes through both digit rollovers and through every leap and non-leap pattern of the two digits.

// File: rtl/rtcy_pkg.sv
`timescale 1ns/1ps
package rtcy_pkg;
   localparam int DIG_W = 4;
   typedef logic [DIG_W-1:0] bcd_t;
   localparam bcd_t BCD_TOP = 4'd9;
endpackage

// File: rtl/rtcy_digit.sv
`timescale 1ns/1ps
module rtcy_digit
   import rtcy_pkg::*;
(
   input  bcd_t d_in,
   input  logic step,
   output bcd_t d_out
);
   always_comb begin
      if (!step)
         d_out = d_in;
      else if (d_in == BCD_TOP)
         d_out = '0;
      else
         d_out = d_in + 1'b1;
   end
endmodule

// File: rtl/rtcy_leap.sv
`timescale 1ns/1ps
module rtcy_leap
   import rtcy_pkg::*;
(
   input  bcd_t units,
   input  logic tens_odd,
   output logic is_leap
);
   always_comb begin
      if (tens_odd)
         is_leap = (units == 4'd2) || (units == 4'd6);
      else
         is_leap = (units == 4'd0) || (units == 4'd4) || (units == 4'd8);
   end
endmodule

// File: rtl/rtc_year_stage.sv
`timescale 1ns/1ps
module rtc_year_stage
   import rtcy_pkg::*;
#(
   parameter int NDIG = 2,
   localparam int YW = NDIG * DIG_W
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_en,
   input  logic          yr_carry,
   input  logic          wr_en,
   input  logic [YW-1:0] wr_data,
   output logic [YW-1:0] rd_data,
   output logic          leap
);
   if (NDIG < 2) begin : g_bad_ndig
      $error("rtc_year_stage: NDIG must be at least 2");
   end

   logic [YW-1:0] yr_q;
   logic [YW-1:0] yr_inc;
   logic [NDIG-1:0] dig_step;
   logic load_wr;
   logic load_cy;

   assign load_wr = rst_n & wr_en & ~run_en;
   assign load_cy = rst_n & yr_carry & ~load_wr;

   for (genvar i = 0; i < NDIG; i++) begin : g_dig
      if (i == 0) begin : g_lsd
         assign dig_step[i] = 1'b1;
      end else begin : g_upper
         assign dig_step[i] = dig_step[i-1] &
                              (yr_q[(i-1)*DIG_W +: DIG_W] == BCD_TOP);
      end
      rtcy_digit u_digit (
         .d_in  (yr_q[i*DIG_W +: DIG_W]),
         .step  (dig_step[i]),
         .d_out (yr_inc[i*DIG_W +: DIG_W])
      );
   end

   always_ff @(posedge clk) begin
      if (load_wr)
         yr_q <= wr_data;
      else if (load_cy)
         yr_q <= yr_inc;
   end

   rtcy_leap u_leap (
      .units    (yr_q[DIG_W-1:0]),
      .tens_odd (yr_q[DIG_W]),
      .is_leap  (leap)
   );

   assign rd_data = yr_q;
endmodule

// File: rtl/rtcy_year_chk.sv
`timescale 1ns/1ps
module rtcy_year_chk #(
   parameter int NDIG = 2,
   localparam int YW = NDIG * 4
)(
   input logic          clk,
   input logic          rst_n,
   input logic          run_en,
   input logic          yr_carry,
   input logic          wr_en,
   input logic [YW-1:0] wr_data,
   input logic [YW-1:0] rd_data,
   input logic          leap
);
   function automatic int low_dec(input logic [YW-1:0] v);
      return int'(v[7:4]) * 10 + int'(v[3:0]);
   endfunction

   function automatic logic low_legal(input logic [YW-1:0] v);
      return (v[7:4] <= 4'd9) && (v[3:0] <= 4'd9);
   endfunction

   // R2
   wr_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !run_en) |=> rd_data == $past(wr_data));

   // R3
   wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && run_en && !yr_carry) |=> $stable(rd_data));

   // R4
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (yr_carry && !(wr_en && !run_en) && low_legal(rd_data)) |=>
      low_dec(rd_data) == (low_dec($past(rd_data)) + 1) % 100);

   // R5
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (yr_carry && !(wr_en && !run_en) && rd_data[7:0] == 8'h99) |=>
      rd_data[7:0] == 8'h00);

   // R6
   carry_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (yr_carry && wr_en && !run_en) |=> rd_data == $past(wr_data));

   // R7
   leap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      low_legal(rd_data) |-> leap == (low_dec(rd_data) % 4 == 0));

   // R8
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!yr_carry && !wr_en) |=> $stable(rd_data));
endmodule

bind rtc_year_stage rtcy_year_chk #(.NDIG(NDIG)) u_year_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .run_en   (run_en),
   .yr_carry (yr_carry),
   .wr_en    (wr_en),
   .wr_data  (wr_data),
   .rd_data  (rd_data),
   .leap     (leap)
);

// File: tb/test_rtc_year_stage.sv
`timescale 1ns/1ps
module test_rtc_year_stage;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run_en = 1'b0;
   logic       yr_carry = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       leap;

   typedef struct {
      logic [7:0] yr;
      logic       lp;
      string      tag;
   } exp_t;

   exp_t sb[$];
   int   yr_m = 0;
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   always #2 clk = ~clk;

   rtc_year_stage i_rtc_year_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_en   (run_en),
      .yr_carry (yr_carry),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .rd_data  (rd_data),
      .leap     (leap)
   );

   function automatic int to_dec(input logic [7:0] b);
      return int'(b[7:4]) * 10 + int'(b[3:0]);
   endfunction

   function automatic logic [7:0] to_bcd(input int d);
      logic [3:0] hi;
      logic [3:0] lo;
      hi = 4'(d / 10);
      lo = 4'(d % 10);
      return {hi, lo};
   endfunction

   // Driver: applies one cycle of stimulus and queues the expected result.
   task automatic step(input bit rn, input bit run, input bit cy,
                       input bit we, input logic [7:0] wd, input string tag);
      exp_t e;
      @(negedge clk);
      rst_n    = rn;
      run_en   = run;
      yr_carry = cy;
      wr_en    = we;
      wr_data  = wd;
      if (rn && we && !run)
         yr_m = to_dec(wd);
      else if (rn && cy)
         yr_m = (yr_m + 1) % 100;
      e.yr  = to_bcd(yr_m);
      e.lp  = (yr_m % 4 == 0);
      e.tag = tag;
      sb.push_back(e);
   endtask

   // Monitor: compares one queued item just after each rising edge.
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (rd_data !== e.yr || leap !== e.lp) begin
               errors++;
               $display("FAIL %s: rd_data=%h leap=%b expected rd_data=%h leap=%b",
                        e.tag, rd_data, leap, e.yr, e.lp);
            end
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: packed BCD layout, tens in [7:4]
      step(1, 0, 0, 1, 8'h37, "R1");
      // R2: halted load
      step(1, 0, 0, 1, 8'h42, "R2");
      // R8: idle hold
      step(1, 0, 0, 0, 8'h00, "R8");
      step(1, 1, 0, 0, 8'h00, "R8");
      // R9: reset neither clears nor accepts loads or carries
      step(0, 0, 1, 1, 8'h12, "R9");
      step(0, 1, 1, 0, 8'h00, "R9");
      step(1, 0, 0, 0, 8'h00, "R9");
      // R3: load ignored while running
      step(1, 1, 0, 1, 8'h55, "R3");
      step(1, 1, 1, 1, 8'h55, "R3");
      // R6: load beats carry in the same cycle
      step(1, 0, 1, 1, 8'h19, "R6");
      // R4 and R7: carry 19 -> 20, leap set
      step(1, 1, 1, 0, 8'h00, "R4");
      step(1, 1, 1, 0, 8'h00, "R7");
      // R5: digit rollover and wrap
      step(1, 0, 0, 1, 8'h09, "R5");
      step(1, 0, 1, 0, 8'h00, "R5");
      step(1, 0, 0, 1, 8'h99, "R5");
      step(1, 1, 1, 0, 8'h00, "R5");
      // R4 / R7 sweep over the whole century
      step(1, 0, 0, 1, 8'h00, "R7");
      for (int k = 0; k < 100; k++) begin
         step(1, 1, 1, 0, 8'h00, (k % 2 == 0) ? "R4" : "R7");
      end
      step(1, 1, 0, 0, 8'h00, "R8");
      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: run did not end, actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule